// File: doc/BRIEF.md
# Hamming Syndrome Decoder for a 512-Byte Sector

This block takes two 24-bit Hamming check words for a 512-byte data sector: the one stored next to the sector in flash, and the one computed again as the sector was read. Their bitwise difference (the syndrome) says whether the sector is clean, holds one data bit that can be repaired, or is damaged beyond repair. When the syndrome also looks damaged beyond what a single data error can produce, the fault is reported as a damaged check word.

A decode is requested with a one-cycle start pulse. One clock later the verdict and the location of the flipped bit (a 9-bit byte index and a 3-bit bit index) are ready, and they stay as they are until the next start pulse. To repair the bit, software or a DMA engine offers a sector byte and its index on a small patch port. The patched byte comes back in the same cycle. It is changed only when the latched verdict is correctable and the index matches the latched byte address.

Top module: `hamm_syn_dec`

## Requirements
- R1: After reset the verdict is CLEAN (2'b00), `done` is 0, and both address outputs are 0.
- R2: `done` rises exactly one clock after a `start` pulse. The verdict and addresses change only on the clock edge that follows a `start`, and otherwise hold their values.
- R3: A syndrome of all zeros (stored word XOR computed word, per byte over the three bytes) gives the verdict CLEAN (2'b00).
- R4: A syndrome with exactly 12 ones gives the verdict FIXABLE (2'b01).
- R5: A syndrome with 1 to 22 ones, but not exactly 12, gives the verdict UNFIXABLE (2'b10).
- R6: A syndrome with 23 or 24 ones gives the verdict CODE_ERR (2'b11).
- R7: The bit address takes bits 0, 1 and 2 from syndrome bits 1, 3 and 5 of byte 0 (syndrome bits [7:0]).
- R8: The byte address is built as follows. Bit 0 comes from syndrome byte 0 bit 7. Bits 1 to 4 come from byte 1 bits 1, 3, 5 and 7. Bits 5 to 8 come from byte 2 bits 1, 3, 5 and 7.
- R9: If the latched verdict is FIXABLE and `patch_idx` equals the latched byte address, `patch_out` is `patch_in` with the addressed bit inverted. In the same cycle this happens, `patch_hit` is 1.
- R10: In every other case `patch_out` equals `patch_in` and `patch_hit` is 0. This covers a different index, and any verdict other than FIXABLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle decode request |
| code_stored | input | 24 | Check word read from the spare area |
| code_calc | input | 24 | Check word computed from the read data |
| done | output | 1 | Pulses one cycle after start |
| verdict | output | 2 | 00 clean, 01 fixable, 10 unfixable, 11 code error |
| byte_addr | output | 9 | Byte index of the flipped bit |
| bit_addr | output | 3 | Bit index inside that byte |
| patch_idx | input | 9 | Index of the byte offered for repair |
| patch_in | input | 8 | Byte offered for repair |
| patch_out | output | 8 | Byte after repair |
| patch_hit | output | 1 | The offered byte was modified |

## Verification
The verdict, the addresses and `done` are registered, so they can be checked one clock after the start pulse. The bench raises `start` on a falling edge and samples on the next falling edge, after the rising edge has captured the result. The patch path is combinational from the latched state. The bench therefore drives the patch index and byte, waits for a moment inside the same clock low phase, and compares before any further edge. It also repeats the patch checks in later cycles without `start`, which shows that the held state does not drift.

// File: rtl/hamm_syn_pkg.sv
package hamm_syn_pkg;
  localparam int CODE_W  = 24;
  localparam int BYTE_AW = 9;
  localparam int BIT_AW  = 3;
  localparam int FIX_ONES = 12;
  localparam int CODE_ERR_ONES = 23;

  typedef enum logic [1:0] {
    V_CLEAN     = 2'b00,
    V_FIXABLE   = 2'b01,
    V_UNFIXABLE = 2'b10,
    V_CODE_ERR  = 2'b11
  } verdict_e;

  function automatic logic [BIT_AW-1:0] pick_bit(input logic [CODE_W-1:0] s);
    return {s[5], s[3], s[1]};
  endfunction

  function automatic logic [BYTE_AW-1:0] pick_byte(input logic [CODE_W-1:0] s);
    return {s[23], s[21], s[19], s[17], s[15], s[13], s[11], s[9], s[7]};
  endfunction

  function automatic verdict_e classify(input logic [5:0] ones);
    if (ones == 6'd0)                  return V_CLEAN;
    else if (ones >= 6'(CODE_ERR_ONES)) return V_CODE_ERR;
    else if (ones == 6'(FIX_ONES))      return V_FIXABLE;
    else                               return V_UNFIXABLE;
  endfunction
endpackage

// File: rtl/hamm_popcnt.sv
module hamm_popcnt #(
  parameter int W = 24,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] ones
);
  logic [CW-1:0] part [W+1];
  assign part[0] = '0;
  for (genvar i = 0; i < W; i++) begin : g_add
    assign part[i+1] = part[i] + CW'(vec[i]);
  end
  assign ones = part[W];
endmodule

// File: rtl/hamm_patch.sv
module hamm_patch #(
  parameter int AW = 9
) (
  input  logic          enable,
  input  logic [AW-1:0] tgt_idx,
  input  logic [2:0]    tgt_bit,
  input  logic [AW-1:0] idx,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          hit
);
  logic [7:0] mask;
  always_comb begin
    hit  = enable && (idx == tgt_idx);
    mask = hit ? (8'd1 << tgt_bit) : 8'd0;
    dout = din ^ mask;
  end
endmodule

// File: rtl/hamm_syn_dec.sv
module hamm_syn_dec
  import hamm_syn_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CODE_W-1:0]  code_stored,
  input  logic [CODE_W-1:0]  code_calc,
  output logic               done,
  output logic [1:0]         verdict,
  output logic [BYTE_AW-1:0] byte_addr,
  output logic [BIT_AW-1:0]  bit_addr,
  input  logic [BYTE_AW-1:0] patch_idx,
  input  logic [7:0]         patch_in,
  output logic [7:0]         patch_out,
  output logic               patch_hit
);
  localparam int NB = CODE_W / 8;
  localparam int CW = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] syn;
  for (genvar b = 0; b < NB; b++) begin : g_xor
    assign syn[b*8 +: 8] = code_stored[b*8 +: 8] ^ code_calc[b*8 +: 8];
  end

  logic [CW-1:0] ones;
  hamm_popcnt #(.W(CODE_W)) u_pop (.vec(syn), .ones(ones));

  verdict_e          nxt_v;
  assign nxt_v = classify(6'(ones));

  verdict_e          v_q;
  logic              done_q;
  logic [BYTE_AW-1:0] byte_q;
  logic [BIT_AW-1:0]  bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= V_CLEAN;
      done_q <= 1'b0;
      byte_q <= '0;
      bit_q  <= '0;
    end else begin
      done_q <= start;
      if (start) begin
        v_q    <= nxt_v;
        byte_q <= pick_byte(syn);
        bit_q  <= pick_bit(syn);
      end
    end
  end

  assign done      = done_q;
  assign verdict   = v_q;
  assign byte_addr = byte_q;
  assign bit_addr  = bit_q;

  wire fix_armed = (v_q == V_FIXABLE);

  hamm_patch #(.AW(BYTE_AW)) u_patch (
    .enable (fix_armed),
    .tgt_idx(byte_q),
    .tgt_bit(bit_q),
    .idx    (patch_idx),
    .din    (patch_in),
    .dout   (patch_out),
    .hit    (patch_hit)
  );

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R2
  AST_HOLD_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(verdict) && $stable(byte_addr) && $stable(bit_addr)); // R2
  AST_ZERO_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && code_stored == code_calc) |=> verdict == V_CLEAN); // R3
  AST_FIX_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $countones(code_stored ^ code_calc) == FIX_ONES) |=> verdict == V_FIXABLE); // R4
  AST_CODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $countones(code_stored ^ code_calc) >= CODE_ERR_ONES) |=> verdict == V_CODE_ERR); // R6
  AST_PATCH_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    patch_hit |-> $onehot0(patch_in ^ patch_out) && (patch_in != patch_out)); // R9
  AST_NO_PATCH_UNLESS_FIX: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict != V_FIXABLE) |-> (patch_out == patch_in) && !patch_hit); // R10
endmodule

// File: tb/hamm_syn_dec_bench.sv
module hamm_syn_dec_bench;
  localparam time TCLK = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [23:0] code_stored = '0, code_calc = '0;
  logic done;
  logic [1:0] verdict;
  logic [8:0] byte_addr;
  logic [2:0] bit_addr;
  logic [8:0] patch_idx = '0;
  logic [7:0] patch_in = '0;
  logic [7:0] patch_out;
  logic patch_hit;

  int n_chk = 0, n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  hamm_syn_dec u_hamm_syn_dec (
    .clk(clk), .rst_n(rst_n), .start(start),
    .code_stored(code_stored), .code_calc(code_calc),
    .done(done), .verdict(verdict), .byte_addr(byte_addr), .bit_addr(bit_addr),
    .patch_idx(patch_idx), .patch_in(patch_in),
    .patch_out(patch_out), .patch_hit(patch_hit)
  );

  function automatic int ones_of(input logic [23:0] s);
    int c = 0;
    for (int i = 0; i < 24; i++) c += int'(s[i]);
    return c;
  endfunction

  function automatic logic [1:0] ref_verdict(input logic [23:0] s);
    int c = ones_of(s);
    if (c == 0) return 2'b00;
    if (c > 22) return 2'b11;
    if (c == 12) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [2:0] ref_bit(input logic [23:0] s);
    logic [2:0] r;
    for (int k = 0; k < 3; k++) r[k] = s[2*k+1];
    return r;
  endfunction

  function automatic logic [8:0] ref_byte(input logic [23:0] s);
    logic [8:0] r;
    for (int k = 0; k < 9; k++) r[k] = s[7 + 2*k];
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [23:0] last_s;

  task automatic decode(input logic [23:0] st, input logic [23:0] ca);
    @(negedge clk);
    code_stored = st; code_calc = ca; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    last_s = st ^ ca;
    check("R2 done", int'(done), 1);
    case (ref_verdict(last_s))
      2'b00: check("R3 verdict", int'(verdict), 0);
      2'b01: check("R4 verdict", int'(verdict), 1);
      2'b10: check("R5 verdict", int'(verdict), 2);
      default: check("R6 verdict", int'(verdict), 3);
    endcase
    check("R7 bit_addr", int'(bit_addr), int'(ref_bit(last_s)));
    check("R8 byte_addr", int'(byte_addr), int'(ref_byte(last_s)));
  endtask

  task automatic patch_probe(input logic [8:0] idx, input logic [7:0] din);
    logic [7:0] exp;
    bit fire;
    patch_idx = idx; patch_in = din;
    #1;
    fire = (ref_verdict(last_s) == 2'b01) && (idx == ref_byte(last_s));
    exp = fire ? (din ^ (8'd1 << ref_bit(last_s))) : din;
    if (fire) begin
      check("R9 patch_out", int'(patch_out), int'(exp));
      check("R9 patch_hit", int'(patch_hit), 1);
    end else begin
      check("R10 patch_out", int'(patch_out), int'(exp));
      check("R10 patch_hit", int'(patch_hit), 0);
    end
  endtask

  function automatic logic [23:0] rand_ones(input int n);
    logic [23:0] v = '0;
    int placed = 0;
    while (placed < n) begin
      int p = int'($urandom_range(23, 0));
      if (!v[p]) begin v[p] = 1'b1; placed++; end
    end
    return v;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [23:0] base;
    void'($urandom(32'd1234));
    last_s = '0;
    #(TCLK*2);
    @(negedge clk);
    check("R1 verdict", int'(verdict), 0);
    check("R1 done", int'(done), 0);
    check("R1 byte_addr", int'(byte_addr), 0);
    check("R1 bit_addr", int'(bit_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 no start done", int'(done), 0);

    decode(24'h5A3C81, 24'h5A3C81);                  // R3 clean
    patch_probe(9'd0, 8'hFF);                        // R10
    decode(24'h000000, 24'hAAAAAA);                  // R4: 12 odd bits, all addr bits 1
    patch_probe(9'h1FF, 8'h00);                      // R9 bit 7
    patch_probe(9'h1FE, 8'h00);                      // R10 wrong index
    decode(24'h000000, 24'h555555);                  // R4: even bits, addresses 0
    patch_probe(9'd0, 8'h01);                        // R9 bit 0
    decode(24'hFFFFFF, 24'h000000);                  // R6: 24 ones
    patch_probe(ref_byte(24'hFFFFFF), 8'h3C);        // R10 code error
    decode(24'h000001, 24'hFFFFFF);                  // R6: 23 ones
    decode(24'h000000, 24'h000003);                  // R5: 2 ones
    decode(24'h000000, 24'h3FFFFF);                  // R5: 22 ones
    patch_probe(ref_byte(24'h3FFFFF), 8'h81);        // R10 unfixable
    decode(24'h000000, 24'h000FFF | 24'h001000);     // R5: 13 ones

    // R2 hold without start
    decode(24'h000000, 24'h0AAAA8 | 24'h800002);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 hold verdict", int'(verdict), int'(ref_verdict(last_s)));
      check("R2 hold byte", int'(byte_addr), int'(ref_byte(last_s)));
      code_calc = 24'($urandom);
      patch_probe(ref_byte(last_s), 8'($urandom));
    end

    for (int i = 0; i < 300; i++) begin
      int pick = int'($urandom_range(3, 0));
      base = 24'($urandom);
      case (pick)
        0: decode(base, base ^ rand_ones(12));
        1: decode(base, base ^ rand_ones(int'($urandom_range(24, 0))));
        2: decode(base, base ^ rand_ones(int'($urandom_range(24, 23))));
        default: decode(base, 24'($urandom));
      endcase
      patch_probe(($urandom_range(1, 0) == 1) ? ref_byte(last_s) : 9'($urandom), 8'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule